// File: doc/BRIEF.md
# Per-Channel QoS Tag Mapper

The block sits in the request path between a set of initiator channels and an interconnect fabric. Every request that passes through it leaves tagged with two quality-of-service values. One is a final 4-bit path identifier, which the fabric uses to pick one of several parallel routes. The other is a 3-bit arbitration priority, where 0 is the most urgent level. Each channel owns a configuration word holding an initial ordering identifier and a priority. A shared 16-entry remap table then turns the initial identifier into the final path identifier. That gives two translation stages: per channel, then per group.

Requests arrive on one valid/ready stream that carries a channel index and a payload. The tagged request leaves through a one-deep output register on a second valid/ready stream. While `out_valid` is high and `out_ready` is low, the output holds every field steady and `in_ready` stays low. Software programs and reads the tables through a simple register port.

A write may land only while the fabric reports no traffic in flight. Otherwise return traffic could be steered down the wrong path. A write presented while `fabric_idle` is low is stalled, and the requester must hold it until the stall drops. Reads are never stalled and have no side effects, so software can confirm each write by reading the register back.

Top module: `qos_tag_mapper`

## Requirements
- R1: After reset, `out_valid` is 0 and `cfg_rvalid` is 0. Every channel word reads 0, and group entry k reads k. A request from any channel is therefore tagged with path identifier 0 and priority 0.
- R2: The configuration word of channel c sits at register address c, where `cfg_addr[5]`=0. Bits 7:4 hold the initial ordering identifier and bits 14:12 hold the priority. All other bits ignore writes and read as 0.
- R3: Group entry k (0..15) sits at address 0x20+k. Bits 3:0 hold the final identifier used for initial identifier k, and all other bits read as 0.
- R4: An accepted request appears on the output one cycle later with the same payload and channel. Its `out_id` is the group entry selected by that channel's initial identifier, and its `out_pri` is that channel's priority.
- R5: A write (`cfg_req`=1, `cfg_we`=1) while `fabric_idle`=0 raises `cfg_stall` in the same cycle and changes no table entry. With `fabric_idle`=1 there is no stall, and the write takes effect at that clock edge.
- R6: A read (`cfg_req`=1, `cfg_we`=0) returns its data on `cfg_rdata` with `cfg_rvalid`=1 one cycle later, and leaves all state unchanged.
- R7: A write to a channel index at or above `N_CH` is ignored, and a read of such an index returns 0.
- R8: While `out_valid`=1 and `out_ready`=0, all output fields hold steady and `in_ready` is 0. Whenever `out_valid`=0, `in_ready` is 1.
- R9: With `out_ready` held at 1, the block accepts one request per cycle with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fabric_idle | input | 1 | Fabric has no outstanding traffic |
| cfg_req | input | 1 | Register access request |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_stall | output | 1 | Write held off; keep the request asserted |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 32 | Read data |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle |
| in_chan | input | 2 | Channel index of the request |
| in_payload | input | 32 | Request payload |
| out_valid | output | 1 | Tagged request valid |
| out_ready | input | 1 | Fabric accepts the tagged request |
| out_chan | output | 2 | Channel index carried through |
| out_payload | output | 32 | Payload carried through |
| out_id | output | 4 | Final path identifier |
| out_pri | output | 3 | Arbitration priority, 0 highest |

## Verification
Requests are sent from every channel under three configurations. In the reset state all tags must be zero. Distinct initial identifiers map through a non-identity group table, which separates the second stage from a direct pass of the first. Two channels share one initial identifier while carrying different priorities, which shows the two fields are taken from the right channel. Further tests cover:
- a write held off for several cycles while the fabric is busy, then completed;
- writes and reads at an unmapped channel index;
- stray upper data bits, which must not alter any field;
- a stalled output with a second request waiting behind it;
- back-to-back requests with no bubbles.

// File: rtl/qos_pkg.sv
package qos_pkg;
  localparam int ID_W    = 4;
  localparam int PRI_W   = 3;
  localparam int ID_LSB  = 4;
  localparam int PRI_LSB = 12;
  localparam int GRP_N   = 1 << ID_W;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [PRI_W-1:0] pri;
  } qos_tag_t;
endpackage

// File: rtl/qos_cfg_regs.sv
module qos_cfg_regs
  import qos_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int AW   = 6,
  parameter int DW   = 32,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fabric_idle,
  input  logic          cfg_req,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          cfg_stall,
  output logic          cfg_rvalid,
  output logic [DW-1:0] cfg_rdata,
  input  logic [CHW-1:0] lk_chan,
  output qos_tag_t      lk_tag
);
  logic [ID_W-1:0]  ch_id  [N_CH];
  logic [PRI_W-1:0] ch_pri [N_CH];
  logic [ID_W-1:0]  grp    [GRP_N];

  logic          wr_go, sel_grp;
  logic [AW-2:0] idx;
  logic [DW-1:0] rd_d;
  wire unused_wdata = ^{cfg_wdata[DW-1:PRI_LSB+PRI_W], cfg_wdata[PRI_LSB-1:ID_LSB+ID_W]};

  assign sel_grp   = cfg_addr[AW-1];
  assign idx       = cfg_addr[AW-2:0];
  assign wr_go     = cfg_req && cfg_we && fabric_idle;
  assign cfg_stall = cfg_req && cfg_we && !fabric_idle;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_id[c]  <= '0;
        ch_pri[c] <= '0;
      end else if (wr_go && !sel_grp && int'(idx) == c) begin
        ch_id[c]  <= cfg_wdata[ID_LSB +: ID_W];
        ch_pri[c] <= cfg_wdata[PRI_LSB +: PRI_W];
      end
    end
  end

  for (genvar k = 0; k < GRP_N; k++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n)
        grp[k] <= ID_W'(k);
      else if (wr_go && sel_grp && int'(idx[ID_W-1:0]) == k)
        grp[k] <= cfg_wdata[ID_W-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (sel_grp) begin
      rd_d[ID_W-1:0] = grp[idx[ID_W-1:0]];
    end else if (int'(idx) < N_CH) begin
      rd_d[ID_LSB +: ID_W]   = ch_id[idx[CHW-1:0]];
      rd_d[PRI_LSB +: PRI_W] = ch_pri[idx[CHW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_req && !cfg_we;
      if (cfg_req && !cfg_we) cfg_rdata <= rd_d;
    end
  end

  always_comb begin
    lk_tag = '0;
    if (int'(lk_chan) < N_CH) begin
      lk_tag.id  = grp[ch_id[lk_chan]];
      lk_tag.pri = ch_pri[lk_chan];
    end
  end
endmodule

// File: rtl/qos_tag_stage.sv
module qos_tag_stage
  import qos_pkg::*;
#(
  parameter int PW  = 32,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CHW-1:0] in_chan,
  input  logic [PW-1:0]  in_payload,
  input  qos_tag_t       in_tag,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CHW-1:0] out_chan,
  output logic [PW-1:0]  out_payload,
  output qos_tag_t       out_tag
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_chan    <= '0;
      out_payload <= '0;
      out_tag     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan    <= in_chan;
        out_payload <= in_payload;
        out_tag     <= in_tag;
      end
    end
  end
endmodule

// File: rtl/qos_tag_mapper.sv
module qos_tag_mapper
  import qos_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int AW   = 6,
  parameter int DW   = 32,
  parameter int PW   = 32,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fabric_idle,
  input  logic             cfg_req,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             cfg_stall,
  output logic             cfg_rvalid,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CHW-1:0]   in_chan,
  input  logic [PW-1:0]    in_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CHW-1:0]   out_chan,
  output logic [PW-1:0]    out_payload,
  output logic [ID_W-1:0]  out_id,
  output logic [PRI_W-1:0] out_pri
);
  qos_tag_t lk_tag, o_tag;

  qos_cfg_regs #(.N_CH(N_CH), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .fabric_idle(fabric_idle),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_stall(cfg_stall),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .lk_chan(in_chan), .lk_tag(lk_tag)
  );

  qos_tag_stage #(.PW(PW), .CHW(CHW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_chan(in_chan),
    .in_payload(in_payload), .in_tag(lk_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_payload(out_payload), .out_tag(o_tag)
  );

  assign out_id  = o_tag.id;
  assign out_pri = o_tag.pri;
endmodule

// File: rtl/qos_tag_mapper_chk.sv
module qos_tag_mapper_chk #(
  parameter int CHW = 2,
  parameter int PW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fabric_idle,
  input logic           cfg_req,
  input logic           cfg_we,
  input logic           cfg_stall,
  input logic           cfg_rvalid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [CHW-1:0] out_chan,
  input logic [PW-1:0]  out_payload,
  input logic [3:0]     out_id,
  input logic [2:0]     out_pri
);
  a_r5_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_we && !fabric_idle) |-> cfg_stall);
  a_r5_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fabric_idle |-> !cfg_stall);
  a_r6_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we) |=> cfg_rvalid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && !cfg_we) |=> !cfg_rvalid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_pri)
                                   && $stable(out_payload) && $stable(out_chan)));
  a_r8_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  a_r8_not_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind qos_tag_mapper qos_tag_mapper_chk #(.CHW(CHW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fabric_idle(fabric_idle), .cfg_req(cfg_req),
  .cfg_we(cfg_we), .cfg_stall(cfg_stall), .cfg_rvalid(cfg_rvalid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_chan(out_chan), .out_payload(out_payload), .out_id(out_id), .out_pri(out_pri)
);

// File: tb/tb_qos_tag_mapper.sv
`timescale 1ns/1ps
module tb_qos_tag_mapper;
  logic clk = 0, rst_n = 0, fabric_idle = 1;
  logic cfg_req = 0, cfg_we = 0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cfg_stall, cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [1:0] in_chan = '0, out_chan;
  logic [31:0] in_payload = '0, out_payload;
  logic [3:0] out_id;
  logic [2:0] out_pri;

  int total = 0, bad = 0;
  logic [3:0] m_id [4];
  logic [2:0] m_pri [4];
  logic [3:0] m_grp [16];

  always #2 clk = ~clk;

  qos_tag_mapper dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    #1 chk("R5 no stall when idle", 32'(cfg_stall), 0);
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
    if (a[5]) m_grp[a[3:0]] = d[3:0];
    else if (a < 4) begin m_id[a[1:0]] = d[7:4]; m_pri[a[1:0]] = d[14:12]; end
  endtask

  task automatic cfg_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_addr = a;
    @(negedge clk);
    chk("R6 read valid", 32'(cfg_rvalid), 1);
    d = cfg_rdata;
    cfg_req = 0;
  endtask

  task automatic send_one(int c, logic [31:0] p, string req);
    @(negedge clk);
    in_valid = 1; in_chan = 2'(c); in_payload = p;
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid"}, 32'(out_valid), 1);
    chk({req, " payload"}, out_payload, p);
    chk({req, " chan"}, 32'(out_chan), c);
    chk({req, " id"}, 32'(out_id), m_grp[m_id[c]]);
    chk({req, " pri"}, 32'(out_pri), m_pri[c]);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 out_valid after reset", 32'(out_valid), 0);
    chk("R1 rvalid after reset", 32'(cfg_rvalid), 0);
    cfg_read(6'd2, d); chk("R1 chan word zero", d, 0);
    cfg_read(6'h2b, d); chk("R1 group identity", d, 32'hb);
    for (int c = 0; c < 4; c++) send_one(c, 32'h100 + c, "R1 reset tag");
  endtask

  task automatic t_fields();
    logic [31:0] d;
    cfg_write(6'd1, 32'hFFFF_FFFF);
    cfg_read(6'd1, d); chk("R2 field mask", d, 32'h0000_70F0);
    cfg_write(6'd0, 32'h0000_3050);
    cfg_read(6'd0, d); chk("R2 fields ch0", d, 32'h0000_3050);
    cfg_write(6'h25, 32'hFFFF_FFF9);
    cfg_read(6'h25, d); chk("R3 group entry mask", d, 32'h9);
    cfg_read(6'd0, d); chk("R6 reread no side effect", d, 32'h0000_3050);
  endtask

  task automatic t_tagging();
    cfg_write(6'd2, 32'h0000_6050);
    cfg_write(6'd3, 32'h0000_20A0);
    cfg_write(6'h2a, 32'h3);
    cfg_write(6'h2f, 32'hc);
    cfg_write(6'd1, 32'h0000_40F0);
    for (int c = 0; c < 4; c++) send_one(c, 32'hA000 + c, "R4 tag");
  endtask

  task automatic t_stall();
    logic [31:0] d;
    fabric_idle = 0;
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = 6'd2; cfg_wdata = 32'h0000_1010;
    #1 chk("R5 stall busy", 32'(cfg_stall), 1);
    repeat (3) @(negedge clk);
    chk("R5 stall held", 32'(cfg_stall), 1);
    cfg_req = 0; cfg_we = 0;
    fabric_idle = 1;
    cfg_read(6'd2, d); chk("R5 unchanged while busy", d, 32'h0000_6050);
    cfg_write(6'd2, 32'h0000_1010);
    cfg_read(6'd2, d); chk("R5 written when idle", d, 32'h0000_1010);
    send_one(2, 32'hBEEF, "R5 new tag");
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    cfg_write(6'd5, 32'h0000_70F0);
    cfg_read(6'd5, d); chk("R7 unmapped reads zero", d, 0);
    for (int c = 0; c < 4; c++) begin
      cfg_read(6'(c), d);
      chk("R7 no alias", d, {17'b0, m_pri[c], 4'b0, m_id[c], 4'b0});
    end
  endtask

  task automatic t_backpressure();
    out_ready = 0;
    send_one(3, 32'hC0DE, "R8 first");
    @(negedge clk);
    in_valid = 1; in_chan = 2'd0; in_payload = 32'hD00D;
    #1 chk("R8 ready low when full", 32'(in_ready), 0);
    repeat (2) @(negedge clk);
    chk("R8 hold payload", out_payload, 32'hC0DE);
    chk("R8 hold id", 32'(out_id), m_grp[m_id[3]]);
    chk("R8 hold pri", 32'(out_pri), m_pri[3]);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R8 second payload", out_payload, 32'hD00D);
    chk("R8 second id", 32'(out_id), m_grp[m_id[0]]);
    @(negedge clk);
    chk("R8 drains", 32'(out_valid), 0);
    #1 chk("R8 ready when empty", 32'(in_ready), 1);
  endtask

  task automatic t_stream();
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1; in_chan = 2'(i % 4); in_payload = 32'hE00 + i;
      @(negedge clk);
      chk("R9 back-to-back valid", 32'(out_valid), 1);
      chk("R9 back-to-back payload", out_payload, 32'hE00 + i);
      chk("R9 back-to-back id", 32'(out_id), m_grp[m_id[i % 4]]);
    end
    in_valid = 0;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin m_id[c] = 0; m_pri[c] = 0; end
    for (int k = 0; k < 16; k++) m_grp[k] = 4'(k);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_tagging();
    t_stall();
    t_unmapped();
    t_backpressure();
    t_stream();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule